// File: doc/BRIEF.md
# Interrupt status and mask unit

This block gathers a chip's interrupt sources into a 32-bit sticky status word and folds them into a single interrupt line through a 32-bit mask word. Five of the sources are watched signals whose every transition, rising or falling, is recorded. Five are level condition inputs coming from the bus timeout counters, the bus response checkers and the receive FIFO. One is derived internally: the transmit FIFO fill level is compared against a programmable threshold.

Software reaches the block through a simple register port with address, write data, a write strobe and combinational read data. A status bit is cleared by writing 1 to it. The clear only takes effect once the condition behind that bit has gone away. Status bits record events whatever the mask says. The mask only decides whether a recorded event drives the interrupt output. Four bits of the status word are plain storage with no interrupt meaning.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status word is 0x00000000, the mask word is 0xFFFFFFFF, the threshold is 0 and `irq_o` is low.
- R2: Each level input sets its status bit at the next clock edge and the bit stays set after the input falls. The bits are `wr_tmo_i` bit 23, `wr_err_i` bit 22, `rd_tmo_i` bit 21, `rd_err_i` bit 20 and `rx_ovf_i` bit 18.
- R3: A write to offset 0x0C with a 1 in a source bit clears that bit at the next edge when its condition is absent in that cycle.
- R4: A write-one-to-clear to a source bit whose condition is true in that cycle leaves the bit set.
- R5: When a set condition and a write-one-to-clear reach the same bit in the same cycle, the bit ends up set.
- R6: Status bits are set whatever the value of their mask bits.
- R7: `irq_o` is high exactly when some status bit is 1 and its mask bit is 0. A mask bit of 1 suppresses that bit.
- R8: `edge_src_i[k]` (k = 0..4) sets status bit 27+k on both a rising and a falling change. The edge history resets to the inputs' reset level (all ones by default), so leaving reset with the inputs at that level records nothing.
- R9: Status bit 17 is set while `tx_level_i` is below the threshold, compared unsigned. The threshold is written and read at offset 0x08 in the low `LVL_W` bits.
- R10: Status bits 26:24 and 19 are plain read/write storage. A write to 0x0C loads them from the write data whatever their value.
- R11: Reads return status at 0x0C, mask at 0x10, threshold at 0x08 and zero at any other offset. Status bits 16:0 always read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_src_i | input | 5 | Monitored signals recorded on both edges (bit k to status 27+k) |
| wr_tmo_i | input | 1 | Write timeout condition |
| wr_err_i | input | 1 | Write response error condition |
| rd_tmo_i | input | 1 | Read timeout condition |
| rd_err_i | input | 1 | Read response error condition |
| rx_ovf_i | input | 1 | Receive FIFO overflow condition |
| tx_level_i | input | LVL_W | Transmit FIFO fill level |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_we_i | input | 1 | Register write strobe, one cycle per write |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| status_o | output | 32 | Status word |
| mask_o | output | 32 | Mask word |
| irq_o | output | 1 | Combined interrupt output |

## Verification
The edge-source assertions compare each input with its value one clock earlier. They assume the five monitored inputs sit at their reset level while reset is applied and during the first clock after it is released. The stimulus therefore drives those inputs to all ones before every reset and changes them only after reset is released. All inputs are assumed to be synchronous to `clk`, and the bench changes them only at the falling edge.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

    localparam int STAT_W     = 32;
    localparam int EDGE_N     = 5;
    localparam int EDGE_LSB   = 27;

    localparam int BIT_WR_TMO = 23;
    localparam int BIT_WR_ERR = 22;
    localparam int BIT_RD_TMO = 21;
    localparam int BIT_RD_ERR = 20;
    localparam int BIT_RX_OVF = 18;
    localparam int BIT_TX_LOW = 17;

    localparam logic [7:0] OFS_THRESH = 8'h08;
    localparam logic [7:0] OFS_STATUS = 8'h0C;
    localparam logic [7:0] OFS_MASK   = 8'h10;

    // bits that carry a source and obey write-one-to-clear
    localparam logic [STAT_W-1:0] SRC_BITS  = 32'hF8F6_0000;
    // plain storage bits inside the status word
    localparam logic [STAT_W-1:0] STORE_BITS = 32'h0708_0000;

    typedef struct packed {
        logic status;
        logic mask;
        logic thresh;
    } wr_sel_t;

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int          N       = 5,
    parameter logic [N-1:0] RST_LVL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] chg_o
);

    typedef struct packed {
        logic [N-1:0] prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= RST_LVL;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar k = 0; k < N; k++) begin : g_chg
            assign chg_o[k] = sig_i[k] ^ st_q.prev[k];
        end
    endgenerate

endmodule

// File: rtl/irq_level_cmp.sv
module irq_level_cmp #(
    parameter int LVL_W = 8
) (
    input  logic [LVL_W-1:0] level_i,
    input  logic [LVL_W-1:0] thresh_i,
    output logic             below_o
);

    always_comb begin
        below_o = (level_i < thresh_i);
    end

endmodule

// File: rtl/irq_reg_access.sv
module irq_reg_access
    import irq_status_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LVL_W  = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [STAT_W-1:0] status_i,
    input  logic [STAT_W-1:0] mask_i,
    input  logic [LVL_W-1:0]  thresh_i,
    output wr_sel_t           sel_o,
    output logic [STAT_W-1:0] rdata_o
);

    localparam logic [ADDR_W-1:0] A_THRESH = ADDR_W'(OFS_THRESH);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
    localparam int                PAD_W    = STAT_W - LVL_W;

    always_comb begin
        sel_o        = '0;
        sel_o.status = we_i && (addr_i == A_STATUS);
        sel_o.mask   = we_i && (addr_i == A_MASK);
        sel_o.thresh = we_i && (addr_i == A_THRESH);
    end

    always_comb begin
        unique case (addr_i)
            A_STATUS: rdata_o = status_i;
            A_MASK:   rdata_o = mask_i;
            A_THRESH: rdata_o = {{PAD_W{1'b0}}, thresh_i};
            default:  rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
    import irq_status_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_sel_t           sel_i,
    input  logic [STAT_W-1:0] wdata_i,
    input  logic [STAT_W-1:0] set_i,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] mask_o,
    output logic [LVL_W-1:0]  thresh_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [STAT_W-1:0] mask;
        logic [LVL_W-1:0]  thresh;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic [STAT_W-1:0] clr_d;
    logic [STAT_W-1:0] src_d;
    logic [STAT_W-1:0] store_d;

    always_comb begin
        st_d = st_q;

        clr_d = sel_i.status ? (wdata_i & SRC_BITS) : '0;
        // a set in this cycle overrides the clear
        src_d = ((st_q.status & ~clr_d) | set_i) & SRC_BITS;

        store_d = sel_i.status ? (wdata_i & STORE_BITS)
                               : (st_q.status & STORE_BITS);

        st_d.status = src_d | store_d;

        if (sel_i.mask) begin
            st_d.mask = wdata_i;
        end
        if (sel_i.thresh) begin
            st_d.thresh = wdata_i[LVL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.status <= '0;
            st_q.mask   <= '1;
            st_q.thresh <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
    assign mask_o   = st_q.mask;
    assign thresh_o = st_q.thresh;
    assign irq_o    = |(st_q.status & ~st_q.mask);

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_status_pkg::*;
#(
    parameter int          ADDR_W       = 8,
    parameter int          LVL_W        = 8,
    parameter logic [4:0]  EDGE_RST_LVL = 5'b11111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        edge_src_i,
    input  logic              wr_tmo_i,
    input  logic              wr_err_i,
    input  logic              rd_tmo_i,
    input  logic              rd_err_i,
    input  logic              rx_ovf_i,
    input  logic [LVL_W-1:0]  tx_level_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    input  logic              reg_we_i,
    output logic [31:0]       reg_rdata_o,
    output logic [31:0]       status_o,
    output logic [31:0]       mask_o,
    output logic              irq_o
);

    logic [EDGE_N-1:0] edge_chg;
    logic              tx_below;
    logic [LVL_W-1:0]  thresh;
    logic [STAT_W-1:0] set_vec;
    wr_sel_t           wr_sel;

    irq_edge_detect #(
        .N       (EDGE_N),
        .RST_LVL (EDGE_RST_LVL)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_i (edge_src_i),
        .chg_o (edge_chg)
    );

    irq_level_cmp #(
        .LVL_W (LVL_W)
    ) u_cmp (
        .level_i  (tx_level_i),
        .thresh_i (thresh),
        .below_o  (tx_below)
    );

    always_comb begin
        set_vec             = '0;
        set_vec[BIT_WR_TMO] = wr_tmo_i;
        set_vec[BIT_WR_ERR] = wr_err_i;
        set_vec[BIT_RD_TMO] = rd_tmo_i;
        set_vec[BIT_RD_ERR] = rd_err_i;
        set_vec[BIT_RX_OVF] = rx_ovf_i;
        set_vec[BIT_TX_LOW] = tx_below;
        for (int k = 0; k < EDGE_N; k++) begin
            set_vec[EDGE_LSB + k] = edge_chg[k];
        end
    end

    irq_reg_access #(
        .ADDR_W (ADDR_W),
        .LVL_W  (LVL_W)
    ) u_acc (
        .addr_i   (reg_addr_i),
        .we_i     (reg_we_i),
        .status_i (status_o),
        .mask_i   (mask_o),
        .thresh_i (thresh),
        .sel_o    (wr_sel),
        .rdata_o  (reg_rdata_o)
    );

    irq_status_regs #(
        .LVL_W (LVL_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (wr_sel),
        .wdata_i  (reg_wdata_i),
        .set_i    (set_vec),
        .status_o (status_o),
        .mask_o   (mask_o),
        .thresh_o (thresh),
        .irq_o    (irq_o)
    );

endmodule

// File: rtl/irq_status_checker.sv
module irq_status_checker #(
    parameter int ADDR_W = 8,
    parameter int LVL_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        edge_src_i,
    input logic              wr_tmo_i,
    input logic              wr_err_i,
    input logic              rd_err_i,
    input logic              rx_ovf_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [31:0]       reg_wdata_i,
    input logic              reg_we_i,
    input logic [31:0]       reg_rdata_o,
    input logic [31:0]       status_o,
    input logic [31:0]       mask_o,
    input logic              irq_o
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(8'h0C);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(8'h10);

    logic stat_wr;
    assign stat_wr = reg_we_i && (reg_addr_i == A_STATUS);

    assert_reset_values_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status_o == 32'h0) && (mask_o == 32'hFFFF_FFFF) && !irq_o);

    assert_level_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tmo_i |=> status_o[23]);

    assert_clear_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && reg_wdata_i[22] && !wr_err_i) |=> !status_o[22]);

    assert_clear_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && reg_wdata_i[20] && rd_err_i) |=> status_o[20]);

    assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && reg_wdata_i[18] && rx_ovf_i) |=> status_o[18]);

    assert_masked_still_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovf_i && mask_o[18]) |=> status_o[18]);

    assert_irq_unmasked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[23] && !mask_o[23]) |-> irq_o);

    assert_irq_all_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o == 32'hFFFF_FFFF) |-> !irq_o);

    generate
        for (genvar k = 0; k < 5; k++) begin : g_edge_chk
            assert_both_edges_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_src_i[k] != $past(edge_src_i[k])) |=> status_o[27 + k]);
        end
    endgenerate

    assert_storage_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (status_o[26:24] == $past(reg_wdata_i[26:24]))
                    && (status_o[19] == $past(reg_wdata_i[19])));

    assert_low_bits_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[16:0] == 17'h0);

    assert_mask_readback_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == A_MASK) |-> (reg_rdata_o == mask_o));

endmodule

bind irq_status_unit irq_status_checker #(
    .ADDR_W (ADDR_W),
    .LVL_W  (LVL_W)
) u_irq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .edge_src_i  (edge_src_i),
    .wr_tmo_i    (wr_tmo_i),
    .wr_err_i    (wr_err_i),
    .rd_err_i    (rd_err_i),
    .rx_ovf_i    (rx_ovf_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_we_i    (reg_we_i),
    .reg_rdata_o (reg_rdata_o),
    .status_o    (status_o),
    .mask_o      (mask_o),
    .irq_o       (irq_o)
);

// File: tb/irq_status_unit_bench.sv
`timescale 1ns/1ps
module irq_status_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  edge_src = 5'h1F;
    logic        wr_tmo = 1'b0, wr_err = 1'b0, rd_tmo = 1'b0, rd_err = 1'b0, rx_ovf = 1'b0;
    logic [7:0]  tx_level = 8'h00;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic        we = 1'b0;
    logic [31:0] rdata, status, mask;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    irq_status_unit u_irq_status_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_src_i  (edge_src),
        .wr_tmo_i    (wr_tmo),
        .wr_err_i    (wr_err),
        .rd_tmo_i    (rd_tmo),
        .rd_err_i    (rd_err),
        .rx_ovf_i    (rx_ovf),
        .tx_level_i  (tx_level),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_we_i    (we),
        .reg_rdata_o (rdata),
        .status_o    (status),
        .mask_o      (mask),
        .irq_o       (irq)
    );

    // lvl order: {wr_tmo, wr_err, rd_tmo, rd_err, rx_ovf}
    typedef struct packed {
        logic [4:0]  edg;
        logic [4:0]  lvl;
        logic [7:0]  txl;
        logic        wr;
        logic [7:0]  ad;
        logic [31:0] wd;
        logic [31:0] exp_stat;
        logic        exp_irq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{5'h1F, 5'h00, 8'h00, 1'b0, 8'h00, 32'h0000_0000, 32'h0000_0000, 1'b0, 4'd1},  // R1 idle
        '{5'h1F, 5'h00, 8'h00, 1'b1, 8'h10, 32'h0000_0000, 32'h0000_0000, 1'b0, 4'd7},  // R7 unmask all
        '{5'h1F, 5'h10, 8'h00, 1'b0, 8'h00, 32'h0000_0000, 32'h0080_0000, 1'b1, 4'd2},  // R2 write timeout
        '{5'h1F, 5'h10, 8'h00, 1'b1, 8'h0C, 32'h0080_0000, 32'h0080_0000, 1'b1, 4'd4},  // R4 blocked
        '{5'h1F, 5'h00, 8'h00, 1'b1, 8'h0C, 32'h0080_0000, 32'h0000_0000, 1'b0, 4'd3},  // R3 cleared
        '{5'h1F, 5'h02, 8'h00, 1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0010_0000, 1'b0, 4'd6},  // R6 masked set
        '{5'h1F, 5'h00, 8'h00, 1'b0, 8'h00, 32'h0000_0000, 32'h0010_0000, 1'b0, 4'd2},  // R2 sticky
        '{5'h1F, 5'h00, 8'h00, 1'b1, 8'h10, 32'hFFEF_FFFF, 32'h0010_0000, 1'b1, 4'd7},  // R7 unmask bit 20
        '{5'h1E, 5'h00, 8'h00, 1'b0, 8'h00, 32'h0000_0000, 32'h0810_0000, 1'b1, 4'd8},  // R8 falling
        '{5'h1E, 5'h00, 8'h00, 1'b1, 8'h0C, 32'h0810_0000, 32'h0000_0000, 1'b0, 4'd3},  // R3 two bits
        '{5'h1F, 5'h00, 8'h00, 1'b0, 8'h00, 32'h0000_0000, 32'h0800_0000, 1'b0, 4'd8},  // R8 rising
        '{5'h1F, 5'h00, 8'h20, 1'b1, 8'h08, 32'h0000_0010, 32'h0800_0000, 1'b0, 4'd9},  // R9 above
        '{5'h1F, 5'h00, 8'h05, 1'b0, 8'h00, 32'h0000_0000, 32'h0802_0000, 1'b0, 4'd9},  // R9 below
        '{5'h1F, 5'h00, 8'h05, 1'b1, 8'h0C, 32'hFFFF_FFFF, 32'h070A_0000, 1'b0, 4'd10}, // R10 store, R4 bit17
        '{5'h1F, 5'h01, 8'h05, 1'b1, 8'h0C, 32'h0004_0000, 32'h0006_0000, 1'b0, 4'd5},  // R5 set wins
        '{5'h1F, 5'h00, 8'h30, 1'b1, 8'h0C, 32'h0006_0000, 32'h0000_0000, 1'b0, 4'd3},  // R3 both gone
        '{5'h00, 5'h00, 8'h30, 1'b1, 8'h10, 32'h7FFF_FFFF, 32'hF800_0000, 1'b1, 4'd8},  // R8 five at once
        '{5'h00, 5'h00, 8'h30, 1'b1, 8'h0C, 32'h0001_FFFF, 32'hF800_0000, 1'b1, 4'd11}, // R11 low bits
        '{5'h00, 5'h0C, 8'h30, 1'b0, 8'h00, 32'h0000_0000, 32'hF860_0000, 1'b1, 4'd2}   // R2 two more
    };

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic read_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        we   = 1'b0;
        addr = a;
        #1;
        check32(tag, rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check32("R1 status after reset", status, 32'h0);
        check32("R1 mask after reset", mask, 32'hFFFF_FFFF);
        check32("R1 irq after reset", {31'h0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            edge_src = VECS[i].edg;
            {wr_tmo, wr_err, rd_tmo, rd_err, rx_ovf} = VECS[i].lvl;
            tx_level = VECS[i].txl;
            we       = VECS[i].wr;
            addr     = VECS[i].ad;
            wdata    = VECS[i].wd;
            @(posedge clk);
            #1;
            check32($sformatf("R%0d vector %0d status", VECS[i].req, i), status, VECS[i].exp_stat);
            check32($sformatf("R%0d vector %0d irq", VECS[i].req, i), {31'h0, irq}, {31'h0, VECS[i].exp_irq});
        end

        {wr_tmo, wr_err, rd_tmo, rd_err, rx_ovf} = 5'h00;
        read_chk("R11 read mask", 8'h10, 32'h7FFF_FFFF);
        read_chk("R9 read threshold", 8'h08, 32'h0000_0010);
        read_chk("R11 read status", 8'h0C, 32'hF860_0000);
        read_chk("R11 read unmapped", 8'h04, 32'h0);

        // reset again with monitored inputs at their reset level
        @(negedge clk);
        edge_src = 5'h1F;
        rst_n    = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        addr  = 8'h08;
        #1;
        check32("R1 status after second reset", status, 32'h0);
        check32("R1 mask after second reset", mask, 32'hFFFF_FFFF);
        check32("R1 threshold after second reset", rdata, 32'h0);
        @(negedge clk);
        #1;
        check32("R8 no edge from reset", status, 32'h0);
        check32("R9 bit17 idle at zero threshold", {31'h0, status[17]}, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule